// File: doc/BRIEF.md
# Transceiver Supply Enable and Fault Supervisor

This block decides when the supply regulator that feeds a bus transceiver is switched on. While no fault is latched, the regulator follows a demand. Demand comes from the transceiver being in its active mode, from detected bus activity, or from a software-owned manual-run bit. The manual-run bit lets the supply run while the transceiver itself is offline. After every enable, the block waits for the regulator's output-good flag. The flag must arrive within a parameterised number of cycles.

A fault is either a missed start-up window or a short-circuit flag while the regulator is on. On a fault the regulator is switched off and held off. In the same cycle, three register bits change together: the supply-OK diagnosis bit goes low, the sticky fault bit goes high, and the manual-run bit is cleared. A one-cycle interrupt pulse is raised if interrupts are enabled. While the fault is latched, ordinary demand is ignored. Only four events restart the regulator: software clears the fault bit while the transceiver is active; a bus wake-up arrives while the transceiver is not active; software sets the manual-run bit; the transceiver enters active mode.

Top module: `supply_guard`

## Requirements
- R1: With no fault latched, `regEn` goes high one cycle after `xcvrActive` or `busActivity` is high. It goes low one cycle after all demand sources (those two and `manualBit`) are low.
- R2: A write (`manWrEn`=1) loads `manWrData` into `manualBit` on the next cycle. A set `manualBit` alone enables the regulator one cycle later.
- R3: If `outGood` has not been seen while `regEn` is high, the regulator faults after exactly `CLT_CYCLES` enabled cycles. `outGood` seen in the last of those cycles still counts as a good start. The window restarts on every new enable.
- R4: `shortFlag` high while `regEn` is high causes a fault, and `regEn` is low on the next cycle.
- R5: A fault drives `regEn` and `diagOk` low, sets `faultBit` and clears `manualBit`, all on the same clock edge. A fault takes priority over a manual-bit write in the same cycle.
- R6: While a fault is latched, none of these turns the regulator on: held `busActivity`, held `xcvrActive`, or `busWake` while `xcvrActive` is high.
- R7: While a fault is latched, `regEn` goes high one cycle after any of these: `faultClr` with `xcvrActive` high; `busWake` with `xcvrActive` low; a manual write of 1; a rising edge of `xcvrActive`.
- R8: `diagOk` goes high one cycle after `outGood` is seen during start-up. It goes low when the regulator is switched off.
- R9: `irqPulse` is high for exactly one cycle after each fault, and only if `irqEnable` was high in the fault cycle.
- R10: `faultClr` clears `faultBit` one cycle later. When `xcvrActive` is low, this leaves the regulator off.
- R11: Synchronous reset (`rstN` low) forces `regEn`, `diagOk`, `faultBit`, `manualBit` and `irqPulse` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| xcvrActive | input | 1 | Transceiver is in active mode |
| busActivity | input | 1 | Bus activity detected |
| busWake | input | 1 | Bus wake-up event |
| manWrEn | input | 1 | Write strobe for the manual-run bit |
| manWrData | input | 1 | Value written to the manual-run bit |
| faultClr | input | 1 | Software clear of the fault bit |
| outGood | input | 1 | Regulator output has reached its good level |
| shortFlag | input | 1 | Short circuit on the regulator output |
| irqEnable | input | 1 | Fault interrupt enable |
| regEn | output | 1 | Regulator enable |
| diagOk | output | 1 | Diagnosis bit: supply running and good |
| faultBit | output | 1 | Sticky supply fault bit |
| manualBit | output | 1 | Manual-run control bit |
| irqPulse | output | 1 | One-cycle fault interrupt |

## Verification
The assertions check several rules on every cycle. On a fault, the bit changes occur together and the regulator is off. The short-circuit shutdown takes one cycle. The start-up window never runs longer than `CLT_CYCLES` enabled cycles. The interrupt pulse is gated, lasts one cycle and tracks the fault bit. Every rising edge of the enable has a legal cause. Some behaviour only the bench scenarios show: which restart events work and which are ignored while latched, the good start in the last window cycle, the fault winning over a same-cycle manual write, and a fault-bit clear that leaves the supply off.

// File: rtl/supply_guard_pkg.sv
`timescale 1ns/1ps
package supply_guard_pkg;

  typedef enum logic [1:0] {
    ST_OFF   = 2'd0,
    ST_START = 2'd1,
    ST_ON    = 2'd2,
    ST_LOCK  = 2'd3
  } runState_t;

  // Strobes from control to datapath, one cycle each
  typedef struct packed {
    logic startRun;  // new enable: restart the start-up window
    logic runGood;   // output good seen during start-up
    logic runStop;   // normal switch-off
    logic faultHit;  // timeout or short: latch off
  } supStrobe_t;

endpackage

// File: rtl/supply_guard_ctrl.sv
`timescale 1ns/1ps
module supply_guard_ctrl
  import supply_guard_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       xcvrActive,
  input  logic       busActivity,
  input  logic       busWake,
  input  logic       manWrEn,
  input  logic       manWrData,
  input  logic       faultClr,
  input  logic       outGood,
  input  logic       shortFlag,
  input  logic       manualBit,
  input  logic       timerDone,
  input  logic       activeRise,
  output supStrobe_t strobe,
  output logic       regEn
);

  runState_t state, stateNext;
  logic demand;
  logic restartEvt;

  assign demand = xcvrActive | busActivity | manualBit;

  // The only four ways out of the latched-off state
  assign restartEvt = (faultClr & xcvrActive)
                    | (busWake & ~xcvrActive)
                    | (manWrEn & manWrData)
                    | activeRise;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      ST_OFF: begin
        if (demand) begin
          stateNext       = ST_START;
          strobe.startRun = 1'b1;
        end
      end
      ST_START: begin
        if (shortFlag) begin
          stateNext       = ST_LOCK;
          strobe.faultHit = 1'b1;
        end else if (!demand) begin
          stateNext      = ST_OFF;
          strobe.runStop = 1'b1;
        end else if (outGood) begin
          stateNext      = ST_ON;
          strobe.runGood = 1'b1;
        end else if (timerDone) begin
          stateNext       = ST_LOCK;
          strobe.faultHit = 1'b1;
        end
      end
      ST_ON: begin
        if (shortFlag) begin
          stateNext       = ST_LOCK;
          strobe.faultHit = 1'b1;
        end else if (!demand) begin
          stateNext      = ST_OFF;
          strobe.runStop = 1'b1;
        end
      end
      ST_LOCK: begin
        if (restartEvt) begin
          stateNext       = ST_START;
          strobe.startRun = 1'b1;
        end
      end
      default: stateNext = ST_OFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_OFF;
    else       state <= stateNext;
  end

  assign regEn = (state == ST_START) || (state == ST_ON);

endmodule

// File: rtl/supply_guard_dp.sv
`timescale 1ns/1ps
module supply_guard_dp
  import supply_guard_pkg::*;
#(
  parameter int CLT_CYCLES = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  supStrobe_t strobe,
  input  logic       manWrEn,
  input  logic       manWrData,
  input  logic       faultClr,
  input  logic       irqEnable,
  input  logic       xcvrActive,
  output logic       diagOk,
  output logic       faultBit,
  output logic       manualBit,
  output logic       irqPulse,
  output logic       timerDone,
  output logic       activeRise
);

  localparam int CW = (CLT_CYCLES > 2) ? $clog2(CLT_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(CLT_CYCLES - 1);

  logic [CW-1:0] winCnt;
  logic          activePrev;

  // Start-up window counter, restarted on every enable
  always_ff @(posedge clk) begin
    if (!rstN)                winCnt <= '0;
    else if (strobe.startRun) winCnt <= '0;
    else if (winCnt != LAST)  winCnt <= winCnt + 1'b1;
  end
  assign timerDone = (winCnt == LAST);

  always_ff @(posedge clk) begin
    if (!rstN) activePrev <= 1'b0;
    else       activePrev <= xcvrActive;
  end
  assign activeRise = xcvrActive & ~activePrev;

  // Register bits; a fault overrides software writes
  always_ff @(posedge clk) begin
    if (!rstN) begin
      diagOk    <= 1'b0;
      faultBit  <= 1'b0;
      manualBit <= 1'b0;
      irqPulse  <= 1'b0;
    end else begin
      irqPulse <= strobe.faultHit & irqEnable;
      if (strobe.faultHit) begin
        diagOk    <= 1'b0;
        faultBit  <= 1'b1;
        manualBit <= 1'b0;
      end else begin
        if (strobe.runGood)      diagOk <= 1'b1;
        else if (strobe.runStop) diagOk <= 1'b0;
        if (faultClr) faultBit  <= 1'b0;
        if (manWrEn)  manualBit <= manWrData;
      end
    end
  end

endmodule

// File: rtl/supply_guard.sv
`timescale 1ns/1ps
module supply_guard
  import supply_guard_pkg::*;
#(
  parameter int CLT_CYCLES = 16
) (
  input  logic clk,
  input  logic rstN,
  input  logic xcvrActive,
  input  logic busActivity,
  input  logic busWake,
  input  logic manWrEn,
  input  logic manWrData,
  input  logic faultClr,
  input  logic outGood,
  input  logic shortFlag,
  input  logic irqEnable,
  output logic regEn,
  output logic diagOk,
  output logic faultBit,
  output logic manualBit,
  output logic irqPulse
);

  supStrobe_t strobe;
  logic timerDone;
  logic activeRise;

  supply_guard_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .xcvrActive (xcvrActive),
    .busActivity(busActivity),
    .busWake    (busWake),
    .manWrEn    (manWrEn),
    .manWrData  (manWrData),
    .faultClr   (faultClr),
    .outGood    (outGood),
    .shortFlag  (shortFlag),
    .manualBit  (manualBit),
    .timerDone  (timerDone),
    .activeRise (activeRise),
    .strobe     (strobe),
    .regEn      (regEn)
  );

  supply_guard_dp #(.CLT_CYCLES(CLT_CYCLES)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .manWrEn   (manWrEn),
    .manWrData (manWrData),
    .faultClr  (faultClr),
    .irqEnable (irqEnable),
    .xcvrActive(xcvrActive),
    .diagOk    (diagOk),
    .faultBit  (faultBit),
    .manualBit (manualBit),
    .irqPulse  (irqPulse),
    .timerDone (timerDone),
    .activeRise(activeRise)
  );

endmodule

// File: rtl/supply_guard_checker.sv
`timescale 1ns/1ps
module supply_guard_checker #(
  parameter int CLT_CYCLES = 16
) (
  input logic clk,
  input logic rstN,
  input logic xcvrActive,
  input logic busActivity,
  input logic busWake,
  input logic manWrEn,
  input logic manWrData,
  input logic faultClr,
  input logic outGood,
  input logic shortFlag,
  input logic irqEnable,
  input logic regEn,
  input logic diagOk,
  input logic faultBit,
  input logic manualBit,
  input logic irqPulse
);

  // Length of the current start-up phase (enabled, not yet good)
  int startLen;
  always_ff @(posedge clk) begin
    if (!rstN)                startLen <= 0;
    else if (!regEn || diagOk) startLen <= 0;
    else                      startLen <= startLen + 1;
  end

  p_window_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    startLen <= CLT_CYCLES);

  p_short_off_r4: assert property (@(posedge clk) disable iff (!rstN)
    (regEn && shortFlag) |=> !regEn);

  p_fault_bits_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(faultBit) |-> (!regEn && !diagOk && !manualBit));

  p_enable_cause_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(regEn) |-> $past(xcvrActive || busActivity || manualBit || busWake
                           || (manWrEn && manWrData) || faultClr));

  p_good_diag_r8: assert property (@(posedge clk) disable iff (!rstN)
    (regEn && !diagOk && outGood && !shortFlag
     && (xcvrActive || busActivity || manualBit)) |=> diagOk);

  p_irq_gate_r9: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |-> ($past(irqEnable) && faultBit && !regEn));

  p_irq_single_r9: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |=> !irqPulse);

endmodule

bind supply_guard supply_guard_checker #(.CLT_CYCLES(CLT_CYCLES)) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .xcvrActive (xcvrActive),
  .busActivity(busActivity),
  .busWake    (busWake),
  .manWrEn    (manWrEn),
  .manWrData  (manWrData),
  .faultClr   (faultClr),
  .outGood    (outGood),
  .shortFlag  (shortFlag),
  .irqEnable  (irqEnable),
  .regEn      (regEn),
  .diagOk     (diagOk),
  .faultBit   (faultBit),
  .manualBit  (manualBit),
  .irqPulse   (irqPulse)
);

// File: tb/supply_guard_tb_top.sv
`timescale 1ns/1ps
module supply_guard_tb_top;

  localparam int CLT = 4;
  localparam int NV  = 24;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic xcvrActive = 0, busActivity = 0, busWake = 0, manWrEn = 0, manWrData = 0;
  logic faultClr = 0, outGood = 0, shortFlag = 0, irqEnable = 0;
  logic regEn, diagOk, faultBit, manualBit, irqPulse;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  supply_guard #(.CLT_CYCLES(CLT)) dut_i (
    .clk(clk), .rstN(rstN), .xcvrActive(xcvrActive), .busActivity(busActivity),
    .busWake(busWake), .manWrEn(manWrEn), .manWrData(manWrData),
    .faultClr(faultClr), .outGood(outGood), .shortFlag(shortFlag),
    .irqEnable(irqEnable), .regEn(regEn), .diagOk(diagOk),
    .faultBit(faultBit), .manualBit(manualBit), .irqPulse(irqPulse)
  );

  // {active,busAct,wake,manWr,manData,clr,good,short,irqEn} _ {regEn,diag,fault,man,irq}
  localparam logic [13:0] VEC [NV] = '{
    14'b100000000_10000,  //  1 R1 active mode enables
    14'b100000100_11000,  //  2 R8 good start
    14'b000000000_00000,  //  3 R1 demand gone, off
    14'b010000000_10000,  //  4 R1 bus activity enables
    14'b010000000_10000,  //  5 R3 still in window
    14'b010000011_00101,  //  6 R4 short -> fault, irq
    14'b010000001_00100,  //  7 R6 activity ignored while latched
    14'b011000000_10100,  //  8 R7 wake while not active restarts
    14'b010000100_11100,  //  9 R8 good
    14'b000110000_00110,  // 10 R2 manual write; demand gone this edge
    14'b000000000_10110,  // 11 R2 manual bit alone enables
    14'b000000000_10110,  // 12 R3 window
    14'b000000000_10110,  // 13 R3 window
    14'b000000000_10110,  // 14 R3 last window cycle
    14'b000000001_00101,  // 15 R3 timeout fault, R5 manual cleared
    14'b000110000_10110,  // 16 R7 manual set restarts
    14'b000000010_00100,  // 17 R9 fault with irq disabled
    14'b000001000_00000,  // 18 R10 clear while not active stays off
    14'b100000000_10000,  // 19 R7 entering active mode restarts
    14'b100000011_00101,  // 20 R4 short
    14'b100001000_10000,  // 21 R7 clear while active restarts
    14'b100000100_11000,  // 22 R8 good
    14'b100110011_00101,  // 23 R5 fault beats manual write
    14'b101000000_00100   // 24 R6 wake while active ignored
  };
  localparam int VREQ [NV] = '{1,8,1,1,3,4,6,7,8,2,2,3,3,3,3,7,9,10,7,4,7,8,5,6};

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    {xcvrActive, busActivity, busWake, manWrEn, manWrData} = '0;
    {faultClr, outGood, shortFlag, irqEnable} = '0;
  endtask

  task automatic chk(input string req, input logic [4:0] act, input logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s {regEn,diag,fault,man,irq} actual=%b expected=%b", req, act, exp);
    end
  endtask

  function automatic logic [4:0] outs();
    return {regEn, diagOk, faultBit, manualBit, irqPulse};
  endfunction

  initial begin
    #800000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    idle();
    rstN = 1'b0;
    cyc(); cyc();
    chk("R11 reset state", outs(), 5'b00000);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      {xcvrActive, busActivity, busWake, manWrEn, manWrData,
       faultClr, outGood, shortFlag, irqEnable} = VEC[i][13:5];
      cyc();
      chk($sformatf("R%0d vector %0d", VREQ[i], i + 1), outs(), VEC[i][4:0]);
    end

    // R11: reset while running
    idle();
    xcvrActive = 1; outGood = 1; rstN = 0;
    cyc(); cyc();
    chk("R11 reset mid-run", outs(), 5'b00000);
    idle(); rstN = 1;
    cyc();
    chk("R11 idle after reset", outs(), 5'b00000);

    // R2: set then clear the manual bit
    manWrEn = 1; manWrData = 1;
    cyc();
    chk("R2 manual set", outs(), 5'b00010);
    idle();
    cyc();
    chk("R2 manual enables", outs(), 5'b10010);
    manWrEn = 1; manWrData = 0;
    cyc();
    chk("R2 manual cleared", outs(), 5'b10000);
    idle();
    cyc();
    chk("R2 off after clear", outs(), 5'b00000);

    // R3: good arriving in the last window cycle is a good start
    xcvrActive = 1;
    cyc();
    chk("R3 enable", outs(), 5'b10000);
    cyc(); cyc(); cyc();
    chk("R3 still starting", outs(), 5'b10000);
    outGood = 1;
    cyc();
    chk("R3 good on last cycle", outs(), 5'b11000);
    outGood = 0;
    cyc();
    chk("R3 stays on", outs(), 5'b11000);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule